// File: doc/BRIEF.md
# Multi-Context Host Mailbox Controller

This block lets several host guests pass control information to an adapter, each through a private context. A single synchronous SRAM is divided into equal, non-overlapping regions, one region per context. A host programmed-I/O write carries a context index, a word offset and a data word. The controller places the word in that context's region and keeps the contexts apart. A write to the doorbell word of a context marks that context as having a pending event. The embedded processor sees the event through an interrupt line and through the number of the lowest-numbered pending context.

The processor reads mailbox words through a one-cycle read port. It acknowledges an event by presenting the number of the context it has serviced. A host write whose offset falls past the end of its region is dropped. That write also sets a sticky error flag for the context that issued it.

The host write channel is valid/ready. A write is accepted on a rising edge where both `hst_valid` and `hst_ready` are high. `hst_ready` drops in any cycle in which the processor reads, because the SRAM has one port and the read takes it. While `hst_ready` is low, the host must hold `hst_valid` and the write fields steady until the write is accepted. The processor read, event and clear pins are plain control pins and have no handshake.

Top module: `ctx_mailbox`

## Requirements
- R1: After a synchronous active-low reset, `evt_valid`, `irq`, `err_flags` and `prd_valid` are all 0.
- R2: An accepted host write with an in-range offset (offset below REGION_WORDS) stores its data at SRAM word {context, offset[7:0]}. A processor read of that 11-bit address in cycle N returns the word on `prd_data` with `prd_valid` high after edge N+1.
- R3: In a cycle where `prd_en` is high, `hst_ready` is low. A processor read always wins the SRAM port.
- R4: A host write still waits while `hst_ready` is low. It is taken on the first edge where ready returns, and it takes effect only once.
- R5: An accepted write with offset ≥ REGION_WORDS (256) changes no SRAM word. It sets bit `ctx` of `err_flags` one edge later, and that bit stays set until reset.
- R6: An accepted write to offset 0 (the doorbell) sets the pending flag of its context. The doorbell word is also stored.
- R7: `evt_valid` is high whenever any context is pending. `evt_ctx` then gives the lowest-numbered pending context.
- R8: `clr_en` with index `clr_ctx` clears that context's pending flag after the edge. Other contexts are not affected.
- R9: If a doorbell write to context c and a clear of context c are taken on the same edge, context c stays pending.
- R10: `irq` is high exactly when at least one context is pending.
- R11: A write to one context leaves the same offset in every other context unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hst_valid | input | 1 | Host write request |
| hst_ready | output | 1 | Host write can be accepted this cycle |
| hst_ctx | input | 3 | Context index of the host write |
| hst_off | input | 10 | Word offset within the context |
| hst_data | input | 32 | Host write data |
| prd_en | input | 1 | Processor read strobe |
| prd_addr | input | 11 | Processor read address {context, offset} |
| prd_data | output | 32 | Read data |
| prd_valid | output | 1 | Read data valid, one cycle after the strobe |
| evt_valid | output | 1 | Some context is pending |
| evt_ctx | output | 3 | Lowest-numbered pending context |
| clr_en | input | 1 | Clear strobe for a pending event |
| clr_ctx | input | 3 | Context whose event is cleared |
| irq | output | 1 | Interrupt to the processor |
| err_flags | output | 8 | Sticky out-of-range flag per context |

## Verification
Each accepted write, clear or read acts on one rising edge. Pending flags, `evt_ctx`, `irq` and `err_flags` show the new value right after that edge. Read data appears after the edge that follows the read strobe. The bench changes inputs on falling edges and samples outputs just before the next rising edge, so every expected value is checked in the cycle it is due. The stall case checks `hst_ready` in the cycle of the read, checks the pending state after the blocked edge, and checks it again after the edge that accepts the write.

// File: rtl/ctx_mailbox_pkg.sv
package ctx_mailbox_pkg;
  localparam int DEF_NUM_CTX      = 8;
  localparam int DEF_REGION_WORDS = 256;
  localparam int DEF_DATA_W       = 32;
  localparam int DEF_HOST_OFF_W   = 10;

  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_HOST = 2'd1,
    PORT_PROC = 2'd2
  } port_owner_e;
endpackage

// File: rtl/mbx_addr_map.sv
module mbx_addr_map #(
  parameter int NUM_CTX      = 8,
  parameter int REGION_WORDS = 256,
  parameter int HOST_OFF_W   = 10,
  localparam int CTX_W       = $clog2(NUM_CTX),
  localparam int REG_AW      = $clog2(REGION_WORDS),
  localparam int MEM_AW      = CTX_W + REG_AW
) (
  input  logic [CTX_W-1:0]      ctx,
  input  logic [HOST_OFF_W-1:0] off,
  output logic                  in_range,
  output logic                  doorbell,
  output logic [MEM_AW-1:0]     mem_addr
);
  // Regions are a power of two, so an offset is in range when its upper bits are zero.
  assign in_range = (off[HOST_OFF_W-1:REG_AW] == '0);
  assign doorbell = in_range && (off[REG_AW-1:0] == '0);
  assign mem_addr = {ctx, off[REG_AW-1:0]};
endmodule

// File: rtl/mbx_sram.sv
module mbx_sram
  import ctx_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];
  port_owner_e       owner;
  logic [AW-1:0]     addr;

  always_comb begin
    if (re)      owner = PORT_PROC;
    else if (we) owner = PORT_HOST;
    else         owner = PORT_IDLE;
  end

  assign addr = (owner == PORT_PROC) ? raddr : waddr;

  always_ff @(posedge clk) begin
    if (owner == PORT_HOST) mem[addr] <= wdata;
    if (owner == PORT_PROC) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end

  // R3: the single port never sees a read and a write together
  a_r3_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    re |-> !we);
  // R2: read data is flagged valid exactly one edge after the strobe
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rvalid);
endmodule

// File: rtl/mbx_event_ctrl.sv
module mbx_event_ctrl #(
  parameter int NUM_CTX = 8,
  localparam int CTX_W  = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [CTX_W-1:0] set_ctx,
  input  logic             clr_en,
  input  logic [CTX_W-1:0] clr_ctx,
  output logic             evt_valid,
  output logic [CTX_W-1:0] evt_ctx,
  output logic             irq
);
  logic [NUM_CTX-1:0] pending_q;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_pend
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_ctx == CTX_W'(g));
    assign hit_clr = clr_en && (clr_ctx == CTX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       pending_q[g] <= 1'b0;
      else if (hit_set) pending_q[g] <= 1'b1;   // set beats a clear on the same edge
      else if (hit_clr) pending_q[g] <= 1'b0;
    end

    // R7: a pending context is reported, never one above a lower pending one
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q[g] |-> (evt_valid && (evt_ctx <= CTX_W'(g))));
    // R9: a doorbell in the same cycle as its own clear leaves the flag set
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_set && hit_clr) |=> pending_q[g]);
    // R8: a clear alone drops the flag
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_clr && !hit_set) |=> !pending_q[g]);
  end

  always_comb begin
    evt_ctx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (pending_q[i]) evt_ctx = CTX_W'(i);
    end
  end

  assign evt_valid = |pending_q;
  assign irq       = |pending_q;

  // R7: the reported context is itself pending
  a_r7_report_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> pending_q[evt_ctx]);
endmodule

// File: rtl/ctx_mailbox.sv
module ctx_mailbox
  import ctx_mailbox_pkg::*;
#(
  parameter int NUM_CTX      = DEF_NUM_CTX,
  parameter int REGION_WORDS = DEF_REGION_WORDS,
  parameter int DATA_W       = DEF_DATA_W,
  parameter int HOST_OFF_W   = DEF_HOST_OFF_W,
  localparam int CTX_W       = $clog2(NUM_CTX),
  localparam int REG_AW      = $clog2(REGION_WORDS),
  localparam int MEM_AW      = CTX_W + REG_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hst_valid,
  output logic                  hst_ready,
  input  logic [CTX_W-1:0]      hst_ctx,
  input  logic [HOST_OFF_W-1:0] hst_off,
  input  logic [DATA_W-1:0]     hst_data,
  input  logic                  prd_en,
  input  logic [MEM_AW-1:0]     prd_addr,
  output logic [DATA_W-1:0]     prd_data,
  output logic                  prd_valid,
  output logic                  evt_valid,
  output logic [CTX_W-1:0]      evt_ctx,
  input  logic                  clr_en,
  input  logic [CTX_W-1:0]      clr_ctx,
  output logic                  irq,
  output logic [NUM_CTX-1:0]    err_flags
);
  logic              accept, in_range, doorbell, mem_we;
  logic [MEM_AW-1:0] wr_addr;

  assign hst_ready = !prd_en;
  assign accept    = hst_valid && hst_ready;

  mbx_addr_map #(
    .NUM_CTX(NUM_CTX), .REGION_WORDS(REGION_WORDS), .HOST_OFF_W(HOST_OFF_W)
  ) u_map (
    .ctx(hst_ctx), .off(hst_off),
    .in_range(in_range), .doorbell(doorbell), .mem_addr(wr_addr)
  );

  assign mem_we = accept && in_range;

  mbx_sram #(.DATA_W(DATA_W), .AW(MEM_AW)) u_sram (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(wr_addr), .wdata(hst_data),
    .re(prd_en), .raddr(prd_addr),
    .rdata(prd_data), .rvalid(prd_valid)
  );

  mbx_event_ctrl #(.NUM_CTX(NUM_CTX)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept && doorbell), .set_ctx(hst_ctx),
    .clr_en(clr_en), .clr_ctx(clr_ctx),
    .evt_valid(evt_valid), .evt_ctx(evt_ctx), .irq(irq)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n) err_flags[g] <= 1'b0;
      else if (accept && !in_range && (hst_ctx == CTX_W'(g))) err_flags[g] <= 1'b1;
    end
  end

  // R5: an out-of-range write never reaches the array
  a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |-> !mem_we);
  // R5: error flags only accumulate
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
  // R10: interrupt tracks the pending report
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == evt_valid);
  // R3: a processor read stalls the host channel
  a_r3_host_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    prd_en |-> !hst_ready);
endmodule

// File: tb/ctx_mailbox_test.sv
module ctx_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_valid, hst_ready;
  logic [2:0]  hst_ctx;
  logic [9:0]  hst_off;
  logic [31:0] hst_data;
  logic        prd_en;
  logic [10:0] prd_addr;
  logic [31:0] prd_data;
  logic        prd_valid, evt_valid, clr_en, irq;
  logic [2:0]  evt_ctx, clr_ctx;
  logic [7:0]  err_flags;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ctx_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_ctx(hst_ctx),
    .hst_off(hst_off), .hst_data(hst_data),
    .prd_en(prd_en), .prd_addr(prd_addr), .prd_data(prd_data), .prd_valid(prd_valid),
    .evt_valid(evt_valid), .evt_ctx(evt_ctx),
    .clr_en(clr_en), .clr_ctx(clr_ctx),
    .irq(irq), .err_flags(err_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    hst_valid = 0; prd_en = 0; clr_en = 0;
  endtask

  // one host write, driven at a falling edge and taken at the next rising edge
  task automatic host_wr(input logic [2:0] c, input logic [9:0] o, input logic [31:0] d);
    @(negedge clk);
    hst_valid = 1; hst_ctx = c; hst_off = o; hst_data = d;
    @(negedge clk);
    hst_valid = 0;
  endtask

  task automatic proc_rd(input logic [10:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    prd_en = 1; prd_addr = a;
    @(negedge clk);
    prd_en = 0;
    d = prd_data; v = prd_valid;
  endtask

  task automatic clear_evt(input logic [2:0] c);
    @(negedge clk);
    clr_en = 1; clr_ctx = c;
    @(negedge clk);
    clr_en = 0;
  endtask

  task automatic t_reset();
    check("R1 evt_valid", {31'd0, evt_valid}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 err_flags", {24'd0, err_flags}, 0);
    check("R1 prd_valid", {31'd0, prd_valid}, 0);
  endtask

  task automatic t_store_isolation();
    logic [31:0] d; logic v;
    host_wr(3'd1, 10'd17, 32'hA1A1_0001);
    host_wr(3'd6, 10'd17, 32'hB6B6_0006);
    host_wr(3'd1, 10'd255, 32'hC0DE_00FF);
    proc_rd({3'd1, 8'd17}, d, v);
    check("R2 data", d, 32'hA1A1_0001);
    check("R2 valid", {31'd0, v}, 1);
    proc_rd({3'd6, 8'd17}, d, v);
    check("R11 other ctx same offset", d, 32'hB6B6_0006);
    proc_rd({3'd1, 8'd255}, d, v);
    check("R2 last word", d, 32'hC0DE_00FF);
    @(negedge clk);
    check("R2 valid drops", {31'd0, prd_valid}, 0);
    check("R6 non-doorbell no event", {31'd0, evt_valid}, 0);
  endtask

  task automatic t_stall();
    logic [31:0] d; logic v;
    @(negedge clk);
    hst_valid = 1; hst_ctx = 3'd5; hst_off = 10'd0; hst_data = 32'h5555_0000;
    prd_en = 1; prd_addr = {3'd1, 8'd17};
    #1 check("R3 ready low on read", {31'd0, hst_ready}, 0);
    @(negedge clk);
    prd_en = 0;
    check("R4 blocked write not taken", {31'd0, evt_valid}, 0);
    check("R3 read still served", prd_data, 32'hA1A1_0001);
    #1 check("R4 ready back", {31'd0, hst_ready}, 1);
    @(negedge clk);
    hst_valid = 0;
    check("R4 held write taken", {31'd0, evt_valid}, 1);
    check("R4 ctx", {29'd0, evt_ctx}, 5);
    proc_rd({3'd5, 8'd0}, d, v);
    check("R6 doorbell word stored", d, 32'h5555_0000);
    clear_evt(3'd5);
    check("R8 cleared", {31'd0, evt_valid}, 0);
  endtask

  task automatic t_out_of_range();
    logic [31:0] d; logic v;
    host_wr(3'd4, 10'd5, 32'h4444_0005);
    host_wr(3'd4, 10'h105, 32'hDEAD_BEEF);
    check("R5 err bit", {24'd0, err_flags}, 32'h10);
    proc_rd({3'd4, 8'd5}, d, v);
    check("R5 word untouched", d, 32'h4444_0005);
    host_wr(3'd4, 10'h100, 32'h0BAD_0BAD);
    check("R5 no event from oor offset 256", {31'd0, evt_valid}, 0);
    host_wr(3'd4, 10'd6, 32'h1);
    check("R5 sticky", {24'd0, err_flags}, 32'h10);
  endtask

  task automatic t_events();
    host_wr(3'd6, 10'd0, 32'h6);
    check("R10 irq on", {31'd0, irq}, 1);
    host_wr(3'd3, 10'd0, 32'h3);
    host_wr(3'd7, 10'd0, 32'h7);
    check("R7 lowest of 3,6,7", {29'd0, evt_ctx}, 3);
    clear_evt(3'd6);
    check("R8 clear other keeps lowest", {29'd0, evt_ctx}, 3);
    clear_evt(3'd3);
    check("R8 next lowest after 3,6 gone", {29'd0, evt_ctx}, 7);
    clear_evt(3'd7);
    check("R10 irq off", {31'd0, irq}, 0);
    check("R7 none", {31'd0, evt_valid}, 0);
  endtask

  task automatic t_race();
    host_wr(3'd2, 10'd0, 32'h2);
    @(negedge clk);
    hst_valid = 1; hst_ctx = 3'd2; hst_off = 10'd0; hst_data = 32'h22;
    clr_en = 1; clr_ctx = 3'd2;
    @(negedge clk);
    idle();
    check("R9 same ctx stays", {31'd0, evt_valid}, 1);
    check("R9 ctx", {29'd0, evt_ctx}, 2);
    @(negedge clk);
    hst_valid = 1; hst_ctx = 3'd3; hst_off = 10'd0; hst_data = 32'h33;
    clr_en = 1; clr_ctx = 3'd2;
    @(negedge clk);
    idle();
    check("R9 other ctx: 2 cleared 3 set", {29'd0, evt_ctx}, 3);
    clear_evt(3'd3);
    check("R8 all clear", {31'd0, evt_valid}, 0);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    hst_ctx = 0; hst_off = 0; hst_data = 0; prd_addr = 0; clr_ctx = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_store_isolation();
    t_stall();
    t_out_of_range();
    t_events();
    t_race();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule